// File: doc/BRIEF.md
# Deferred Exception Tag Register File

This block is a general-purpose register file in which every register carries one extra bit, a poison tag, recording that a fault happened while the register's value was being produced. It lets speculative operations run ahead of the branches or predicates that guard them without trapping. A speculative operation that faults is not reported. Instead its destination is marked, and the mark travels into every value computed from it. An execution unit reads its sources through the two read ports, which return each source's tag next to its data. The unit ORs those tags and hands the result back with its write, so the block can decide whether the destination is tagged or a fault is raised.

Software places a check operation at the point where the speculated instruction would originally have executed. The check names one register. If that register is tagged, the block asks for recovery. A non-speculative operation never defers: a fault it raises, or a poisoned source it consumes, is signalled on the cycle of its writeback. Register 0 is constant zero with a permanently clear tag. A write and a read or check of the same register in the same cycle see the value being written.

Top module: `etag_regfile`

## Requirements
- R1: A write with wr_spec=1 stores wr_data and sets the destination tag to 1 when wr_exc or wr_src_tag is 1. Otherwise it sets the tag to 0.
- R2: A write with wr_spec=1 never asserts exc_now, whatever wr_exc and wr_src_tag are.
- R3: A write with wr_spec=0 and wr_exc=1 or wr_src_tag=1 asserts exc_now combinationally in the same cycle. It stores wr_data with the destination tag 0.
- R4: A write with wr_spec=0, wr_exc=0 and wr_src_tag=0 stores wr_data and clears the destination tag.
- R5: Each read port returns, combinationally, the data and tag last written to the addressed register.
- R6: When wr_en=1 and a read port or the check port addresses wr_addr (not 0) in the same cycle, that port sees the data and tag being written.
- R7: chk_recover equals 1 exactly when chk_valid=1 and the tag of chk_addr is 1. Otherwise it is 0, and a check changes no stored state.
- R8: Register 0 reads as data 0 with tag 0, and writes to it are ignored. A non-speculative fault aimed at it still raises exc_now.
- R9: An active-low rst_n clears every tag. Its release takes effect after two rising clock edges, and writes are ignored until then.
- R10: exc_now is 0 whenever wr_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Destination register |
| wr_data | input | DW | Result value |
| wr_spec | input | 1 | Producing operation is speculative |
| wr_exc | input | 1 | Producing operation faulted |
| wr_src_tag | input | 1 | OR of the tags of the sources the operation read |
| rd_a_addr | input | AW | Read port A address |
| rd_a_data | output | DW | Read port A data |
| rd_a_tag | output | 1 | Read port A tag |
| rd_b_addr | input | AW | Read port B address |
| rd_b_data | output | DW | Read port B data |
| rd_b_tag | output | 1 | Read port B tag |
| chk_valid | input | 1 | Check operation strobe |
| chk_addr | input | AW | Register the check tests |
| chk_recover | output | 1 | Recovery request from the check |
| exc_now | output | 1 | Immediate exception from a non-speculative write |

## Verification
The hardest situation to reach from the ports is a tag that outlives several overwrites. A speculative fault must land on a register, stay through unrelated traffic, and then meet a check or a read, sometimes in the same cycle as another write to that register. Random stimulus uses a small register window, so addresses collide often and tagged registers are both consumed and overwritten. The bench feeds read tags back as wr_src_tag, so poison spreads naturally. Directed sequences add a spec fault followed by a same-cycle clean overwrite and check, and writes to register 0.

// File: rtl/etag_pkg.sv
package etag_pkg;
  typedef struct packed {
    logic tag;
    logic raise;
  } tag_res_t;
endpackage

// File: rtl/etag_tag_logic.sv
module etag_tag_logic
  import etag_pkg::*;
(
  input  logic     wr_en,
  input  logic     spec,
  input  logic     exc,
  input  logic     src_tag,
  output tag_res_t res
);
  logic fault;
  always_comb begin
    fault     = exc | src_tag;
    res.tag   = spec & fault;
    res.raise = wr_en & ~spec & fault;
  end
endmodule

// File: rtl/etag_storage.sv
module etag_storage #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     wtag,
  output logic [NREG-1:0][DW-1:0]  data_q,
  output logic [NREG-1:0]          tag_q
);
  assign data_q[0] = '0;
  assign tag_q[0]  = 1'b0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    logic          en;
    logic [DW-1:0] data_d;
    logic          tag_d;

    always_comb begin
      en     = we && (waddr == AW'(r));
      data_d = en ? wdata : data_q[r];
      tag_d  = en ? wtag  : tag_q[r];
    end

    always_ff @(posedge clk) begin
      if (en) data_q[r] <= data_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tag_q[r] <= 1'b0;
      else if (en) tag_q[r] <= tag_d;
    end
  end
endmodule

// File: rtl/etag_rd_port.sv
module etag_rd_port #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [AW-1:0]           addr,
  input  logic [NREG-1:0][DW-1:0] data_q,
  input  logic [NREG-1:0]         tag_q,
  input  logic                    byp_we,
  input  logic [AW-1:0]           byp_addr,
  input  logic [DW-1:0]           byp_data,
  input  logic                    byp_tag,
  output logic [DW-1:0]           rdata,
  output logic                    rtag
);
  logic hit;
  always_comb begin
    hit   = byp_we && (byp_addr == addr);
    rdata = hit ? byp_data : data_q[addr];
    rtag  = hit ? byp_tag  : tag_q[addr];
  end
endmodule

// File: rtl/etag_check.sv
module etag_check #(
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            chk_valid,
  input  logic [AW-1:0]   chk_addr,
  input  logic [NREG-1:0] tag_q,
  input  logic            byp_we,
  input  logic [AW-1:0]   byp_addr,
  input  logic            byp_tag,
  output logic            recover
);
  logic tag_sel;
  always_comb begin
    tag_sel = (byp_we && byp_addr == chk_addr) ? byp_tag : tag_q[chk_addr];
    recover = chk_valid & tag_sel;
  end
endmodule

// File: rtl/etag_regfile.sv
module etag_regfile
  import etag_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_spec,
  input  logic          wr_exc,
  input  logic          wr_src_tag,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  output logic          rd_a_tag,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data,
  output logic          rd_b_tag,
  input  logic          chk_valid,
  input  logic [AW-1:0] chk_addr,
  output logic          chk_recover,
  output logic          exc_now
);
  localparam int NRD = 2;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  tag_res_t                res;
  logic                    we_eff;
  logic [NREG-1:0][DW-1:0] data_q;
  logic [NREG-1:0]         tag_q;

  etag_tag_logic u_tag (
    .wr_en   (wr_en),
    .spec    (wr_spec),
    .exc     (wr_exc),
    .src_tag (wr_src_tag),
    .res     (res)
  );

  assign we_eff  = wr_en && rst_int_n && (wr_addr != '0);
  assign exc_now = res.raise;

  etag_storage #(.NREG(NREG), .DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (we_eff),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .wtag   (res.tag),
    .data_q (data_q),
    .tag_q  (tag_q)
  );

  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][DW-1:0] rd_data;
  logic [NRD-1:0]         rd_tag;

  assign rd_addr = {rd_b_addr, rd_a_addr};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    etag_rd_port #(.NREG(NREG), .DW(DW)) u_rd (
      .addr     (rd_addr[p]),
      .data_q   (data_q),
      .tag_q    (tag_q),
      .byp_we   (we_eff),
      .byp_addr (wr_addr),
      .byp_data (wr_data),
      .byp_tag  (res.tag),
      .rdata    (rd_data[p]),
      .rtag     (rd_tag[p])
    );
  end

  assign rd_a_data = rd_data[0];
  assign rd_a_tag  = rd_tag[0];
  assign rd_b_data = rd_data[1];
  assign rd_b_tag  = rd_tag[1];

  etag_check #(.NREG(NREG)) u_chk_port (
    .chk_valid (chk_valid),
    .chk_addr  (chk_addr),
    .tag_q     (tag_q),
    .byp_we    (we_eff),
    .byp_addr  (wr_addr),
    .byp_tag   (res.tag),
    .recover   (chk_recover)
  );
endmodule

// File: rtl/etag_regfile_chk.sv
module etag_regfile_chk #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          wr_spec,
  input logic          wr_exc,
  input logic          wr_src_tag,
  input logic [AW-1:0] rd_a_addr,
  input logic [DW-1:0] rd_a_data,
  input logic          rd_a_tag,
  input logic          chk_valid,
  input logic [AW-1:0] chk_addr,
  input logic          chk_recover,
  input logic          exc_now
);
  a_r2_spec_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_spec) |-> !exc_now);

  a_r3_nonspec_raise: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !wr_spec && (wr_exc || wr_src_tag)) |-> exc_now);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_en |-> !exc_now);

  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_a_addr == '0) |-> (rd_a_data == '0 && !rd_a_tag));

  a_r7_no_check_no_req: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!chk_valid || chk_addr == '0) |-> !chk_recover);

  a_r1_tag_sticks: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_spec && (wr_exc || wr_src_tag) && wr_addr != '0)
    |=> (!chk_valid || chk_addr != $past(wr_addr) ||
         (wr_en && wr_addr == chk_addr) || chk_recover));
endmodule

bind etag_regfile etag_regfile_chk #(.NREG(NREG), .DW(DW)) u_etag_chk (.*);

// File: tb/etag_regfile_test.sv
module etag_regfile_test;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int AW   = $clog2(NREG);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_spec, wr_exc, wr_src_tag, chk_valid;
  logic [AW-1:0] wr_addr, rd_a_addr, rd_b_addr, chk_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic          rd_a_tag, rd_b_tag, chk_recover, exc_now;

  always #4 clk = ~clk;

  etag_regfile #(.NREG(NREG), .DW(DW)) uut (.*);

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] m_data [NREG];
  logic          m_tag  [NREG];
  logic          m_val  [NREG];

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_tag(input logic spec, input logic exc, input logic src);
    return spec & (exc | src);
  endfunction

  function automatic logic exp_raise(input logic en, input logic spec, input logic exc, input logic src);
    return en & ~spec & (exc | src);
  endfunction

  function automatic logic hit(input logic [AW-1:0] a);
    return wr_en && wr_addr == a && a != 0;
  endfunction

  task automatic check_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic t, input string req);
    logic          et;
    logic [DW-1:0] ed;
    logic          dv;
    if (a == 0) begin et = 0; ed = 0; dv = 1; end
    else if (hit(a)) begin et = exp_tag(wr_spec, wr_exc, wr_src_tag); ed = wr_data; dv = 1; end
    else begin et = m_tag[a]; ed = m_data[a]; dv = m_val[a]; end
    check({req, " tag"}, DW'(t), DW'(et));
    if (dv) check({req, " data"}, d, ed);
  endtask

  // drive at negedge, check after settle, update model at posedge
  task automatic step(input logic en, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic sp, input logic ex, input logic st,
                      input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                      input logic cv, input logic [AW-1:0] ca);
    logic et;
    @(negedge clk);
    wr_en = en; wr_addr = wa; wr_data = wd; wr_spec = sp; wr_exc = ex; wr_src_tag = st;
    rd_a_addr = ra; rd_b_addr = rb; chk_valid = cv; chk_addr = ca;
    #1;
    check(sp ? "R2 exc_now" : (en ? "R3 exc_now" : "R10 exc_now"),
          DW'(exc_now), DW'(exp_raise(en, sp, ex, st)));
    check_read(ra, rd_a_data, rd_a_tag, hit(ra) ? "R6 port A" : (ra == 0 ? "R8 port A" : "R5 port A"));
    check_read(rb, rd_b_data, rd_b_tag, hit(rb) ? "R6 port B" : (rb == 0 ? "R8 port B" : "R5 port B"));
    et = (ca == 0) ? 1'b0 : (hit(ca) ? exp_tag(sp, ex, st) : m_tag[ca]);
    check("R7 chk_recover", DW'(chk_recover), DW'(cv & et));
    @(posedge clk);
    if (en && wa != 0) begin
      m_data[wa] = wd; m_tag[wa] = exp_tag(sp, ex, st); m_val[wa] = 1;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NREG; i++) begin m_tag[i] = 0; m_val[i] = 0; m_data[i] = 0; end
    wr_en = 0; wr_addr = 0; wr_data = 0; wr_spec = 0; wr_exc = 0; wr_src_tag = 0;
    rd_a_addr = 0; rd_b_addr = 0; chk_valid = 0; chk_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: writes in the two edges after release are ignored
    @(negedge clk); wr_en = 1; wr_addr = 5; wr_spec = 1; wr_exc = 1;
    @(negedge clk); wr_en = 0; wr_spec = 0; wr_exc = 0;
    repeat (2) @(negedge clk);
    for (int r = 0; r < NREG; r++) begin
      chk_valid = 1; chk_addr = AW'(r); #1;
      check("R9 reset tag clear", DW'(chk_recover), 0);
    end
    chk_valid = 0;

    // R1 spec fault sets tag; R2 silent
    step(1, 5, 32'h1111, 1, 1, 0, 5, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 5, 5, 1, 5);
    check("R1 tag after spec fault", DW'(rd_a_tag), 1);
    check("R7 recover on tagged", DW'(chk_recover), 1);
    // R1 propagation via source tag
    step(1, 6, 32'h2222, 1, 0, 1, 6, 5, 0, 0);
    step(0, 0, 0, 0, 0, 0, 6, 0, 0, 0);
    check("R1 propagated tag", DW'(rd_a_tag), 1);
    // R4 clean nonspec overwrite clears, with same-cycle check (R6)
    step(1, 5, 32'h3333, 0, 0, 0, 5, 5, 1, 5);
    check("R6 check bypass clear", DW'(chk_recover), 0);
    step(0, 0, 0, 0, 0, 0, 5, 0, 1, 5);
    check("R4 tag cleared", DW'(rd_a_tag), 0);
    check("R4 data", rd_a_data, 32'h3333);
    // R3 nonspec consumer of poison raises, tag stays clear
    step(1, 7, 32'h4444, 0, 0, 1, 7, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 7, 0, 1, 7);
    check("R3 dest tag clear", DW'(rd_a_tag), 0);
    // R8 writes to r0 ignored, fault still raised
    step(1, 0, 32'hdead, 0, 1, 0, 0, 0, 1, 0);
    step(1, 0, 32'hbeef, 1, 1, 0, 0, 0, 0, 0);
    check("R8 r0 data", rd_a_data, 0);

    // random mix, small window to force collisions, tags fed back
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wa, ra, rb, ca;
      logic st;
      wa = AW'($urandom_range(0, 7));
      ra = AW'($urandom_range(0, 7));
      rb = ($urandom_range(0, 3) == 0) ? wa : AW'($urandom_range(0, 7));
      ca = ($urandom_range(0, 3) == 0) ? wa : AW'($urandom_range(0, 7));
      st = (ra != 0 && m_tag[ra]) || ($urandom_range(0, 9) == 0);
      step(1'($urandom_range(0, 1)), wa, $urandom(),
           1'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0),
           st, ra, rb, 1'($urandom_range(0, 1)), ca);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule